// File: doc/BRIEF.md
# Twin Machine-Cycle Timer/Counter

This block holds two timer/counter channels behind a small register port. A free-running divider turns the core clock into machine cycles, one for every twelve clocks. In timer function a channel advances once per machine cycle. In counter function it advances once per falling edge seen on its count pin, with the pin sampled once per machine cycle.

Each channel has a low byte and a high byte. The channel's two-bit mode groups these bytes into one of four shapes:
- a 13-bit counter whose low five bits act as a prescaler;
- a full 16-bit counter;
- an 8-bit counter that reloads from the high byte;
- a split arrangement, in which channel 0's two bytes become separate 8-bit counters and the high one borrows channel 1's run bit and overflow flag.

Counting needs the channel's run bit. If the channel's gate bit is set, the gate pin must also be high, which lets software time the width of a pulse. A rollover of a channel latches its overflow flag, and the flag stays set until software clears it.

The register port is plain: a write strobe with an address and data, and a combinational read mux. Register map, as 3-bit addresses:
- 0: mode.
- 1: run bits, bit 0 for channel 0 and bit 1 for channel 1.
- 2: flags, bit 0 for channel 0 and bit 1 for channel 1.
- 3: channel 0 low byte.
- 4: channel 0 high byte.
- 5: channel 1 low byte.
- 6: channel 1 high byte.

Top module: `tmr_pair`

## Requirements
- R1: A machine-cycle tick occurs once every DIV (12) clocks. In timer function an enabled channel advances by exactly one count per tick, and no count register changes between ticks unless it is written.
- R2: In counter function the count pin is sampled on each tick. A sample of 1 followed by a sample of 0 advances the count by one on the following tick. Every fall is counted when each pin level is held for at least two machine cycles.
- R3: The previous-sample register resets to 0, so a count pin that is held low through reset adds no count.
- R4: A channel counts only while its run bit is 1 and either its gate bit is 0 or its gate pin is 1.
- R5: Mode 00 is a 13-bit counter. The low five bits of the low byte prescale by 32 and carry into the high byte. The upper three bits of the low byte are left untouched. The flag is set when all 13 bits roll over to zero.
- R6: Mode 01 cascades the low and high bytes into one 16-bit counter. The flag is set on the rollover from 0xFFFF.
- R7: Mode 10 counts in the low byte only. On a low-byte overflow the low byte is loaded from the high byte and the flag is set. The high byte never changes except by a write.
- R8: With channel 0 in mode 11, channel 0's low byte is an 8-bit counter under channel 0's run, gate and select bits, and it sets flag 0. Channel 0's high byte counts machine cycles while run bit 1 is set, and its rollover sets flag 1. A channel 1 placed in mode 11 holds its count.
- R9: A flag stays set until a write of 0 to it. A hardware set in the same cycle as a clearing write leaves the flag set.
- R10: The mode byte is laid out, from bit 7 down to bit 0, as: gate 1, select 1, mode 1 (2 bits), gate 0, select 0, mode 0 (2 bits). A select bit of 1 chooses counter function. All registers reset to 0, and setting a run bit does not clear the counts.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 3 | Write address |
| wr_data | input | 8 | Write data |
| rd_addr | input | 3 | Read address |
| rd_data | output | 8 | Read data, combinational from rd_addr |
| gate_pin | input | 2 | Per-channel external gate |
| cnt_pin | input | 2 | Per-channel external count input |
| ovf | output | 2 | Overflow flags of channels 1 and 0 |

## Verification
The bench targets the carries that are easy to get wrong:
- In mode 00 the carry must come out of bit 4, not bit 7. A design that carries from bit 7 would leave the high byte still and would alter the upper three bits of the low byte.
- In mode 10 a reload that drops the high byte, or that increments it, shows up in the low byte after the wrap.

It drives the split mode with only run bit 1 set. A design that routes the wrong run bit or the wrong flag leaves flag 1 clear, or moves the low byte.

It lines a clearing write up with a hardware overflow on the same edge. A design that lets the write win loses the flag.

It holds the count pin low through reset. An edge detector that starts from 1 adds a false count.

// File: rtl/tmr_pkg.sv
package tmr_pkg;
  typedef enum logic [1:0] {
    MD_13  = 2'd0,
    MD_16  = 2'd1,
    MD_RLD = 2'd2,
    MD_SPL = 2'd3
  } tmr_mode_e;

  typedef struct packed {
    logic      gate;
    logic      ext;
    tmr_mode_e mode;
  } tmr_cfg_t;

  localparam logic [2:0] A_MODE = 3'd0;
  localparam logic [2:0] A_RUN  = 3'd1;
  localparam logic [2:0] A_FLAG = 3'd2;
  localparam logic [2:0] A_LO0  = 3'd3;
  localparam logic [2:0] A_HI0  = 3'd4;
  localparam logic [2:0] A_LO1  = 3'd5;
  localparam logic [2:0] A_HI1  = 3'd6;
endpackage

// File: rtl/tmr_tick.sv
module tmr_tick #(
  parameter int DIV = 12
) (
  input  logic clk,
  input  logic rst_n,
  output logic tick
);
  localparam int CW = (DIV > 1) ? $clog2(DIV) : 1;
  logic [CW-1:0] cnt;

  assign tick = (cnt == CW'(DIV - 1));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    cnt <= '0;
    else if (tick) cnt <= '0;
    else           cnt <= cnt + 1'b1;
  end
endmodule

// File: rtl/tmr_edge.sv
module tmr_edge #(
  parameter int N = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         tick,
  input  logic [N-1:0] pin,
  output logic [N-1:0] fall
);
  for (genvar i = 0; i < N; i++) begin : g_pin
    logic cur_s, old_s;
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        cur_s <= 1'b0;
        old_s <= 1'b0;
      end else if (tick) begin
        cur_s <= pin[i];
        old_s <= cur_s;
      end
    end
    assign fall[i] = old_s & ~cur_s;
  end
endmodule

// File: rtl/tmr_chan.sv
module tmr_chan
  import tmr_pkg::*;
#(
  parameter int BW = 8,
  parameter int PW = 5
) (
  input  logic          clk,
  input  logic          rst_n,
  input  tmr_mode_e     mode,
  input  logic          inc_lo,
  input  logic          inc_hi,
  input  logic          wr_lo,
  input  logic          wr_hi,
  input  logic [BW-1:0] wdata,
  output logic [BW-1:0] lo,
  output logic [BW-1:0] hi,
  output logic          ovf_main,
  output logic          ovf_hi
);
  logic [BW-1:0] lo_n, hi_n;

  always_comb begin
    lo_n     = lo;
    hi_n     = hi;
    ovf_main = 1'b0;
    ovf_hi   = 1'b0;
    if (inc_lo) begin
      unique case (mode)
        MD_13: begin
          if (lo[PW-1:0] == '1) begin
            lo_n[PW-1:0] = '0;
            hi_n         = hi + 1'b1;
            ovf_main     = (hi == '1);
          end else begin
            lo_n[PW-1:0] = lo[PW-1:0] + 1'b1;
          end
        end
        MD_16: begin
          {hi_n, lo_n} = {hi, lo} + 1'b1;
          ovf_main     = &{hi, lo};
        end
        MD_RLD: begin
          if (lo == '1) begin
            lo_n     = hi;
            ovf_main = 1'b1;
          end else begin
            lo_n = lo + 1'b1;
          end
        end
        MD_SPL: begin
          lo_n     = lo + 1'b1;
          ovf_main = (lo == '1);
        end
      endcase
    end
    if (inc_hi && mode == MD_SPL) begin
      hi_n   = hi + 1'b1;
      ovf_hi = (hi == '1);
    end
    if (wr_lo) lo_n = wdata;
    if (wr_hi) hi_n = wdata;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      lo <= '0;
      hi <= '0;
    end else begin
      lo <= lo_n;
      hi <= hi_n;
    end
  end
endmodule

// File: rtl/tmr_pair.sv
module tmr_pair
  import tmr_pkg::*;
#(
  parameter int DIV = 12,
  parameter int BW  = 8,
  parameter int PW  = 5
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          wr_en,
  input  logic [2:0]    wr_addr,
  input  logic [BW-1:0] wr_data,
  input  logic [2:0]    rd_addr,
  output logic [BW-1:0] rd_data,
  input  logic [1:0]    gate_pin,
  input  logic [1:0]    cnt_pin,
  output logic [1:0]    ovf
);
  localparam int NCH = 2;

  logic [7:0]     mode_q;
  logic [NCH-1:0] run_q, flag_q, set_v;
  logic           tick;
  logic [NCH-1:0] fall;
  tmr_cfg_t       cfg [NCH];
  logic [NCH-1:0] inc_lo, inc_hi, ovf_m, ovf_h, en;
  logic [BW-1:0]  lo_v [NCH];
  logic [BW-1:0]  hi_v [NCH];
  logic           split0;

  assign cfg[0] = tmr_cfg_t'(mode_q[3:0]);
  assign cfg[1] = tmr_cfg_t'(mode_q[7:4]);
  assign split0 = (cfg[0].mode == MD_SPL);

  tmr_tick #(.DIV(DIV)) u_tick (.clk(clk), .rst_n(rst_n), .tick(tick));

  tmr_edge #(.N(NCH)) u_edge (
    .clk(clk), .rst_n(rst_n), .tick(tick), .pin(cnt_pin), .fall(fall)
  );

  for (genvar c = 0; c < NCH; c++) begin : g_ch
    localparam logic [2:0] ALO = (c == 0) ? A_LO0 : A_LO1;
    localparam logic [2:0] AHI = (c == 0) ? A_HI0 : A_HI1;
    logic ev;
    assign en[c] = run_q[c] & (~cfg[c].gate | gate_pin[c]);
    assign ev    = tick & (cfg[c].ext ? fall[c] : 1'b1);
    if (c == 0) begin : g_main
      assign inc_lo[c] = en[c] & ev;
      assign inc_hi[c] = tick & run_q[1];
    end else begin : g_aux
      assign inc_lo[c] = en[c] & ev & (cfg[c].mode != MD_SPL);
      assign inc_hi[c] = 1'b0;
    end
    tmr_chan #(.BW(BW), .PW(PW)) u_chan (
      .clk(clk), .rst_n(rst_n), .mode(cfg[c].mode),
      .inc_lo(inc_lo[c]), .inc_hi(inc_hi[c]),
      .wr_lo(wr_en && wr_addr == ALO), .wr_hi(wr_en && wr_addr == AHI),
      .wdata(wr_data), .lo(lo_v[c]), .hi(hi_v[c]),
      .ovf_main(ovf_m[c]), .ovf_hi(ovf_h[c])
    );
  end

  assign set_v[0] = ovf_m[0];
  assign set_v[1] = split0 ? ovf_h[0] : ovf_m[1];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mode_q <= '0;
      run_q  <= '0;
      flag_q <= '0;
    end else begin
      if (wr_en && wr_addr == A_MODE) mode_q <= wr_data[7:0];
      if (wr_en && wr_addr == A_RUN)  run_q  <= wr_data[NCH-1:0];
      flag_q <= ((wr_en && wr_addr == A_FLAG) ? wr_data[NCH-1:0] : flag_q) | set_v;
    end
  end

  assign ovf = flag_q;

  always_comb begin
    rd_data = '0;
    unique case (rd_addr)
      A_MODE:  rd_data[7:0]     = mode_q;
      A_RUN:   rd_data[NCH-1:0] = run_q;
      A_FLAG:  rd_data[NCH-1:0] = flag_q;
      A_LO0:   rd_data = lo_v[0];
      A_HI0:   rd_data = hi_v[0];
      A_LO1:   rd_data = lo_v[1];
      A_HI1:   rd_data = hi_v[1];
      default: rd_data = '0;
    endcase
  end
endmodule

// File: rtl/tmr_pair_chk.sv
module tmr_pair_chk
  import tmr_pkg::*;
(
  input logic       clk,
  input logic       rst_n,
  input logic       tick,
  input logic       wr_en,
  input logic [2:0] wr_addr,
  input logic [7:0] mode_q,
  input logic [1:0] run_q,
  input logic [7:0] lo0,
  input logic [7:0] hi0,
  input logic [7:0] lo1,
  input logic [7:0] hi1,
  input logic [1:0] ovf
);
  AST_NO_TICK_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (!tick && !wr_en) |=> ($stable(lo0) && $stable(hi0) && $stable(lo1) && $stable(hi1))); // R1

  AST_RUN_OFF_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (!run_q[0] && !(wr_en && wr_addr == A_LO0)) |=> $stable(lo0)); // R4

  AST_RELOAD_HI_FIXED: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_q[1:0] == 2'b10 && !(wr_en && wr_addr == A_HI0)) |=> $stable(hi0)); // R7

  AST_CH1_SPLIT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_q[5:4] == 2'b11 && !(wr_en && (wr_addr == A_LO1 || wr_addr == A_HI1)))
      |=> ($stable(lo1) && $stable(hi1))); // R8

  AST_FLAG_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    (ovf[0] && !(wr_en && wr_addr == A_FLAG)) |=> ovf[0]); // R9
endmodule

bind tmr_pair tmr_pair_chk u_chk (
  .clk(clk), .rst_n(rst_n), .tick(tick), .wr_en(wr_en), .wr_addr(wr_addr),
  .mode_q(mode_q), .run_q(run_q), .lo0(lo_v[0]), .hi0(hi_v[0]),
  .lo1(lo_v[1]), .hi1(hi_v[1]), .ovf(ovf)
);

// File: tb/tb_tmr_pair.sv
module tb_tmr_pair;
  localparam int CLK_P = 10;
  localparam int MC    = 12;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       wr_en = 1'b0;
  logic [2:0] wr_addr = '0;
  logic [7:0] wr_data = '0;
  logic [2:0] rd_addr = '0;
  logic [7:0] rd_data;
  logic [1:0] gate_pin = '0;
  logic [1:0] cnt_pin = '0;
  logic [1:0] ovf;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  tmr_pair dut (.*);

  always #(CLK_P/2) clk = ~clk;

  // vector: mode(2) lo(8) hi(8) cycles(8) exp_lo(8) exp_hi(8) exp_flag(1)
  localparam logic [42:0] VEC [9] = '{
    {2'd1, 8'h00, 8'h00, 8'd5, 8'h05, 8'h00, 1'b0},
    {2'd1, 8'hFE, 8'h00, 8'd3, 8'h01, 8'h01, 1'b0},
    {2'd1, 8'hFE, 8'hFF, 8'd3, 8'h01, 8'h00, 1'b1},
    {2'd0, 8'h1E, 8'h00, 8'd3, 8'h01, 8'h01, 1'b0},
    {2'd0, 8'hFF, 8'hFF, 8'd1, 8'hE0, 8'h00, 1'b1},
    {2'd0, 8'hA0, 8'h12, 8'd4, 8'hA4, 8'h12, 1'b0},
    {2'd2, 8'hFE, 8'hF0, 8'd3, 8'hF1, 8'hF0, 1'b1},
    {2'd2, 8'h10, 8'h80, 8'd5, 8'h15, 8'h80, 1'b0},
    {2'd3, 8'hFE, 8'h20, 8'd3, 8'h01, 8'h20, 1'b1}
  };

  task automatic chk(input string req, input logic [15:0] act, input logic [15:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [2:0] a, input logic [7:0] d);
    @(negedge clk);
    wr_en = 1'b1; wr_addr = a; wr_data = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic rd(input logic [2:0] a, output logic [7:0] d);
    rd_addr = a;
    #1;
    d = rd_data;
  endtask

  task automatic run_win(input logic [1:0] rb, input int n);
    wr(tmr_pkg::A_RUN, {6'd0, rb});
    repeat (MC*n - 1) @(posedge clk);
    wr(tmr_pkg::A_RUN, 8'h00);
  endtask

  task automatic finish_up();
    if (!done) begin
      done = 1'b1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    fails++;
    $display("FAIL watchdog: run did not finish actual=hung expected=done");
    finish_up();
  end

  initial begin
    logic [7:0] d, d2;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    // R10 reset state
    for (int a = 0; a < 7; a++) begin
      rd(3'(a), d);
      chk("R10 reset register", {8'h0, d}, 16'h0);
    end
    chk("R9 flags after reset", {14'h0, ovf}, 16'h0);
    // R3: pin low through reset, counter mode running
    wr(tmr_pkg::A_MODE, 8'h05);
    wr(tmr_pkg::A_RUN, 8'h01);
    repeat (5*MC) @(posedge clk);
    wr(tmr_pkg::A_RUN, 8'h00);
    rd(tmr_pkg::A_LO0, d);
    chk("R3 no count from low pin at reset", {8'h0, d}, 16'h0);

    // table walk, channel 0 timer function
    for (int i = 0; i < 9; i++) begin
      logic [42:0] v;
      v = VEC[i];
      wr(tmr_pkg::A_FLAG, 8'h00);
      wr(tmr_pkg::A_MODE, {6'd0, v[42:41]});
      wr(tmr_pkg::A_LO0, v[40:33]);
      wr(tmr_pkg::A_HI0, v[32:25]);
      run_win(2'b01, int'(v[24:17]));
      @(negedge clk);
      rd(tmr_pkg::A_LO0, d);
      rd(tmr_pkg::A_HI0, d2);
      // R1 R5 R6 R7 R8 R10: per-mode counting from preloaded values
      chk($sformatf("R1/R5-R8 vec%0d low byte", i), {8'h0, d}, {8'h0, v[16:9]});
      chk($sformatf("R10 vec%0d high byte", i), {8'h0, d2}, {8'h0, v[8:1]});
      chk($sformatf("R9 vec%0d flag0", i), {15'h0, ovf[0]}, {15'h0, v[0]});
    end

    // R4 gating
    wr(tmr_pkg::A_MODE, 8'h09);
    wr(tmr_pkg::A_LO0, 8'h00);
    wr(tmr_pkg::A_HI0, 8'h00);
    gate_pin[0] = 1'b0;
    run_win(2'b01, 5);
    rd(tmr_pkg::A_LO0, d);
    chk("R4 gate pin low blocks count", {8'h0, d}, 16'h0);
    gate_pin[0] = 1'b1;
    run_win(2'b01, 5);
    rd(tmr_pkg::A_LO0, d);
    chk("R4 gate pin high allows count", {8'h0, d}, 16'h5);

    // R2 counter function, edges of 24-clock levels
    wr(tmr_pkg::A_MODE, 8'h05);
    @(negedge clk); cnt_pin[0] = 1'b1;
    repeat (3*MC) @(negedge clk);
    wr(tmr_pkg::A_LO0, 8'h00);
    wr(tmr_pkg::A_HI0, 8'h00);
    wr(tmr_pkg::A_RUN, 8'h01);
    repeat (2*MC) @(negedge clk);
    for (int k = 0; k < 4; k++) begin
      cnt_pin[0] = 1'b0;
      repeat (2*MC) @(negedge clk);
      cnt_pin[0] = 1'b1;
      repeat (2*MC) @(negedge clk);
    end
    repeat (3*MC) @(negedge clk);
    wr(tmr_pkg::A_RUN, 8'h00);
    rd(tmr_pkg::A_LO0, d);
    chk("R2 four falling edges counted", {8'h0, d}, 16'h4);

    // R8 split: high byte of channel 0 under run bit 1
    wr(tmr_pkg::A_FLAG, 8'h00);
    wr(tmr_pkg::A_MODE, 8'h03);
    wr(tmr_pkg::A_LO0, 8'h00);
    wr(tmr_pkg::A_HI0, 8'hFE);
    run_win(2'b10, 3);
    rd(tmr_pkg::A_HI0, d);
    chk("R8 split high byte counts on run1", {8'h0, d}, 16'h01);
    rd(tmr_pkg::A_LO0, d);
    chk("R8 split low byte idle without run0", {8'h0, d}, 16'h00);
    chk("R8 split high overflow sets flag1", {15'h0, ovf[1]}, 16'h1);
    chk("R8 split leaves flag0 clear", {15'h0, ovf[0]}, 16'h0);

    // R8 channel 1 in mode 11 holds
    wr(tmr_pkg::A_MODE, 8'h30);
    wr(tmr_pkg::A_LO1, 8'h05);
    run_win(2'b11, 4);
    rd(tmr_pkg::A_LO1, d);
    chk("R8 channel 1 frozen in mode 11", {8'h0, d}, 16'h05);

    // R6 channel 1 16-bit rollover
    wr(tmr_pkg::A_FLAG, 8'h00);
    wr(tmr_pkg::A_MODE, 8'h10);
    wr(tmr_pkg::A_LO1, 8'hFF);
    wr(tmr_pkg::A_HI1, 8'hFF);
    run_win(2'b10, 2);
    rd(tmr_pkg::A_LO1, d);
    rd(tmr_pkg::A_HI1, d2);
    chk("R6 channel 1 low after wrap", {8'h0, d}, 16'h01);
    chk("R6 channel 1 high after wrap", {8'h0, d2}, 16'h00);
    chk("R9 channel 1 flag set", {15'h0, ovf[1]}, 16'h1);

    // R9 hardware set wins over clearing write on the same edge
    wr(tmr_pkg::A_MODE, 8'h02);
    wr(tmr_pkg::A_HI0, 8'hFF);
    wr(tmr_pkg::A_LO0, 8'hFF);
    wr(tmr_pkg::A_FLAG, 8'h00);
    wr(tmr_pkg::A_RUN, 8'h01);
    for (int p = 0; p < 3*MC; p++) begin
      @(negedge clk);
      if (ovf[0]) break;
    end
    repeat (MC - 1) @(posedge clk);
    wr(tmr_pkg::A_FLAG, 8'h00);
    chk("R9 set beats clear on same edge", {15'h0, ovf[0]}, 16'h1);
    wr(tmr_pkg::A_FLAG, 8'h00);
    chk("R9 clear by write of zero", {15'h0, ovf[0]}, 16'h0);
    wr(tmr_pkg::A_RUN, 8'h00);

    finish_up();
  end
endmodule